// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. It runs on the bus clock. It holds four pieces of state: a divide setting, a reload (initial) count, a live current count and a timer entry. The timer entry carries the interrupt vector, a mask bit and a periodic/one-shot mode bit. Software starts a countdown by writing a nonzero initial count. The current count then drops by one on every divided tick. When it reaches its end, the block raises a one-cycle request that carries the programmed vector, unless the entry is masked.

In periodic mode the count reloads from the initial count and keeps running. In one-shot mode the count stops at zero. A software-enable level input models the controller's software disable. While that input is low, every write to the timer entry keeps the mask bit set. The moment the input drops, the mask bit in the entry is set.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divide setting stores only bits 0, 1 and 3 of a write, and bit 2 always reads 0. It does not change without a write.
- R2: The divisor is 2^n, where n = ({bit3, bit1, bit0} + 1) mod 8. So 4'b1011 divides by 1, 4'b0000 by 2 and 4'b1010 by 128. After an initial-count write, the current count drops by one every divisor cycles. The first drop comes divisor cycles after the write edge.
- R3: Writing the initial count loads that value into both the initial and the current count, and restarts the divided tick phase.
- R4: On the tick that would take the current count from 1 to 0 with the entry unmasked, irq_pulse is high for exactly one cycle. irq_vector then equals entry bits [7:0] as they stood at that tick.
- R5: With entry bit 9 = 1 (periodic), that tick reloads the current count with the initial count, and counting carries on.
- R6: With entry bit 9 = 0 (one-shot), the current count stays at 0 after the end, and no further request is raised until the initial count is written again.
- R7: Writing an initial count of 0 stops the timer at a current count of 0 and raises no request.
- R8: With entry bit 8 = 1 (mask), the end of a countdown raises no request. A periodic timer still reloads.
- R9: After reset, the initial count, current count and divide setting are 0, the entry is 10'h100 (masked, vector 0) and irq_pulse is low.
- R10: While sw_enable is low, any entry write stores bit 8 as 1.
- R11: A falling edge of sw_enable sets entry bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Software enable level; low means software-disabled |
| div_we | input | 1 | Divide setting write strobe |
| div_wdata | input | 4 | Divide setting write data |
| icnt_we | input | 1 | Initial count write strobe |
| icnt_wdata | input | 32 | Initial count write data |
| ent_we | input | 1 | Timer entry write strobe |
| ent_wdata | input | 10 | Entry: [7:0] vector, [8] mask, [9] periodic |
| div_cfg | output | 4 | Stored divide setting |
| init_count | output | 32 | Stored initial count |
| cur_count | output | 32 | Live current count |
| ent_value | output | 10 | Stored timer entry |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions assume the write strobes are clean, known-valued levels sampled on the clock edge. They also assume that sw_enable changes only between edges, and that at most the initial-count strobe decides what the count does in a cycle. The step check allows for one drop, a reload or a hold, so a divide change in the middle of a count does not trip it. The bench model does assume the divide setting and entry stay fixed during a countdown. For that reason the random phases write the divider and entry only before the initial-count write that starts each run. Software disable is exercised only in directed phases, while no countdown is live.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_enable,
  input  logic             div_we,
  input  logic [3:0]       div_wdata,
  input  logic             icnt_we,
  input  logic [CNT_W-1:0] icnt_wdata,
  input  logic             ent_we,
  input  logic [VEC_W+1:0] ent_wdata,
  output logic [3:0]       div_cfg,
  output logic [CNT_W-1:0] init_count,
  output logic [CNT_W-1:0] cur_count,
  output logic [VEC_W+1:0] ent_value,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int ENT_W    = VEC_W + 2;
  localparam int MASK_BIT = VEC_W;
  localparam int MODE_BIT = VEC_W + 1;
  localparam int PRE_W    = 7;
  localparam logic [ENT_W-1:0] MASK_ONE = ENT_W'(1) << MASK_BIT;

  logic [3:0]       div_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [ENT_W-1:0] ent_q;
  logic [PRE_W-1:0] pre_q;
  logic             sw_q, irq_q;
  logic [VEC_W-1:0] vec_q;

  logic [2:0]       div_exp;
  logic [PRE_W-1:0] div_mask;
  logic             tick;

  assign div_exp  = {div_q[3], div_q[1:0]} + 3'd1;
  assign div_mask = PRE_W'((8'd1 << div_exp) - 8'd1);
  assign tick     = (pre_q & div_mask) == div_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      init_q <= '0;
      cur_q  <= '0;
      ent_q  <= MASK_ONE;
      pre_q  <= '0;
      sw_q   <= 1'b0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      sw_q  <= sw_enable;
      irq_q <= 1'b0;
      if (div_we) div_q <= div_wdata & 4'b1011;
      if (ent_we)
        ent_q <= ent_wdata | (sw_enable ? '0 : MASK_ONE);
      else if (sw_q && !sw_enable)
        ent_q[MASK_BIT] <= 1'b1;
      if (icnt_we) begin
        init_q <= icnt_wdata;
        cur_q  <= icnt_wdata;
        pre_q  <= '0;
      end else if (cur_q != '0) begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (cur_q == CNT_W'(1)) begin
            irq_q <= !ent_q[MASK_BIT];
            vec_q <= ent_q[VEC_W-1:0];
            cur_q <= ent_q[MODE_BIT] ? init_q : '0;
          end else begin
            cur_q <= cur_q - 1'b1;
          end
        end
      end
    end
  end

  assign div_cfg    = div_q;
  assign init_count = init_q;
  assign cur_count  = cur_q;
  assign ent_value  = ent_q;
  assign irq_pulse  = irq_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_countdown_timer_chk.sv
module irq_countdown_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_enable,
  input logic             div_we,
  input logic             icnt_we,
  input logic [CNT_W-1:0] icnt_wdata,
  input logic             ent_we,
  input logic [3:0]       div_cfg,
  input logic [CNT_W-1:0] init_count,
  input logic [CNT_W-1:0] cur_count,
  input logic [VEC_W+1:0] ent_value,
  input logic             irq_pulse,
  input logic [VEC_W-1:0] irq_vector
);
  assert_div_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !div_we |=> $stable(div_cfg));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!icnt_we && cur_count != '0) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1 ||
       cur_count == init_count));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    icnt_we |=> (cur_count == $past(icnt_wdata) && init_count == $past(icnt_wdata)));
  assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_vector == $past(ent_value[VEC_W-1:0]));
  assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !icnt_we) |=> (cur_count == '0 && !irq_pulse));
  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(ent_value[VEC_W]));
  assert_disabled_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && !sw_enable) |=> ent_value[VEC_W]);
  assert_disable_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_enable) |=> ent_value[VEC_W]);
endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .div_we(div_we),
  .icnt_we(icnt_we), .icnt_wdata(icnt_wdata), .ent_we(ent_we),
  .div_cfg(div_cfg), .init_count(init_count), .cur_count(cur_count),
  .ent_value(ent_value), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
);

// File: tb/irq_countdown_timer_tb_top.sv
module irq_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_enable = 1'b1;
  logic        div_we = 1'b0;
  logic [3:0]  div_wdata = '0;
  logic        icnt_we = 1'b0;
  logic [31:0] icnt_wdata = '0;
  logic        ent_we = 1'b0;
  logic [9:0]  ent_wdata = '0;
  logic [3:0]  div_cfg;
  logic [31:0] init_count, cur_count;
  logic [9:0]  ent_value;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .div_we(div_we), .div_wdata(div_wdata),
    .icnt_we(icnt_we), .icnt_wdata(icnt_wdata),
    .ent_we(ent_we), .ent_wdata(ent_wdata),
    .div_cfg(div_cfg), .init_count(init_count), .cur_count(cur_count),
    .ent_value(ent_value), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  function automatic int f_divisor(input logic [3:0] cfg);
    int n;
    n = (int'({cfg[3], cfg[1:0]}) + 1) % 8;
    return 1 << n;
  endfunction

  function automatic int f_count(input int n, input int d, input int c, input bit per);
    int k;
    k = c / d;
    if (per) return n - (k % n);
    return (k >= n) ? 0 : n - k;
  endfunction

  function automatic bit f_irq(input int n, input int d, input int c, input bit per, input bit msk);
    int k;
    if (msk || c == 0 || (c % d) != 0) return 1'b0;
    k = c / d;
    if (per) return (k % n) == 0;
    return k == n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [3:0] v);
    @(negedge clk); div_we = 1'b1; div_wdata = v;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic wr_ent(input logic [9:0] v);
    @(negedge clk); ent_we = 1'b1; ent_wdata = v;
    @(negedge clk); ent_we = 1'b0;
  endtask

  task automatic wr_icnt(input logic [31:0] v);
    @(negedge clk); icnt_we = 1'b1; icnt_wdata = v;
    @(negedge clk); icnt_we = 1'b0;
  endtask

  task automatic run_phase(input logic [3:0] cfg, input int n, input bit per,
                           input bit msk, input logic [7:0] vec, input int cycles);
    int d;
    int pulses;
    d = f_divisor(cfg);
    pulses = 0;
    wr_div(cfg);
    wr_ent({per, msk, vec});
    wr_icnt(32'(n));
    check("R3 load", cur_count, n);
    for (int c = 1; c <= cycles; c++) begin
      bit ei;
      @(posedge clk); @(negedge clk);
      ei = f_irq(n, d, c, per, msk);
      check(per ? "R2/R5 periodic count" : "R2/R6 one-shot count",
            cur_count, f_count(n, d, c, per));
      check(msk ? "R8 masked pulse" : "R4 pulse", irq_pulse, ei);
      if (ei && irq_pulse) begin
        check("R4 vector", irq_vector, vec);
        pulses++;
      end
    end
    if (!per && !msk && cycles >= n * d) check("R6 single pulse", pulses, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 div", div_cfg, 0);
    check("R9 init", init_count, 0);
    check("R9 cur", cur_count, 0);
    check("R9 entry", ent_value, 10'h100);
    check("R9 irq", irq_pulse, 0);

    wr_div(4'hF);
    check("R1 div bits", div_cfg, 4'hB);
    wr_div(4'h4);
    check("R1 div bit2", div_cfg, 4'h0);

    run_phase(4'b1011, 3, 1'b0, 1'b0, 8'h31, 8);
    run_phase(4'b0000, 2, 1'b1, 1'b0, 8'h42, 14);
    run_phase(4'b1010, 1, 1'b1, 1'b0, 8'h77, 300);
    run_phase(4'b1011, 1, 1'b1, 1'b0, 8'h05, 6);
    run_phase(4'b0001, 3, 1'b1, 1'b1, 8'h99, 40);

    wr_ent(10'h0A0);
    wr_div(4'b1011);
    wr_icnt(32'd5);
    repeat (2) @(negedge clk);
    wr_icnt(32'd0);
    check("R7 stop", cur_count, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 no pulse", irq_pulse, 0);
    end
    check("R7 held", cur_count, 0);

    for (int p = 0; p < 30; p++) begin
      logic [3:0] cfg;
      int n;
      int d;
      cfg = 4'($urandom_range(0, 15));
      n = $urandom_range(1, 5);
      d = f_divisor(cfg);
      run_phase(cfg, n, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                8'($urandom_range(0, 255)), n * d * 2 + 3);
    end

    wr_ent(10'h012);
    check("R11 pre", ent_value, 10'h012);
    @(negedge clk); sw_enable = 1'b0;
    @(negedge clk);
    check("R11 disable sets mask", ent_value, 10'h112);
    wr_ent(10'h234);
    check("R10 forced mask", ent_value, 10'h334);
    @(negedge clk); sw_enable = 1'b1;
    wr_ent(10'h234);
    check("R10 enabled write", ent_value, 10'h234);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule